// File: doc/BRIEF.md
# Dispatch Readiness Checker by Instruction Class

This block sits between the operand-ready queue and the dispatch slot of a wave scheduler. Each cycle it receives the class bits of one candidate instruction and a set of flags. The flags say which execution resources will be able to accept work in the next cycle: the scalar ALU, the vector ALU, and the issue units, buses, request FIFOs, coalescer and outstanding-request check of the memory paths. From these it returns one dispatch-ready bit. When the instruction cannot go, it raises one strobe for every resource condition that blocks it, all in the same cycle. The block does not work out the resource states itself. They arrive already decided.

The class is resolved in a fixed priority: no-op first, then end-of-program, then barrier/branch/ALU, then vector global memory, scalar global memory, vector local memory and vector flat. A combination that matches none of these raises an error output, and that instruction is never reported ready. A bank of saturating event counters, one per stall reason plus one for successful checks, records how often each outcome happened. A synchronous clear input resets the bank.

The whole decision is combinational and is qualified by `chk_vld`. No data is buffered, so there is no back-pressure: the caller holds the candidate for as long as it wants an answer. While `chk_vld` is low, all outputs are quiet and the counters hold their values.

Top module: `disp_ready_chk`

## Requirements
- R1: A no-op that is scalar is ready only when the scalar ALU is ready (otherwise stall bit 0). A no-op that is vector is ready only when the vector ALU is ready (otherwise stall bit 1). The ALU of the other kind has no effect.
- R2: A vector end-of-program instruction is always ready. A scalar one is blocked only by a scalar ALU that is not ready, and then raises stall bit 0.
- R3: Barrier, branch and ALU instructions need the scalar ALU (stall bit 0) when scalar, and the vector ALU (stall bit 1) otherwise.
- R4: A vector global-memory instruction needs four conditions: global issue ready (bit 2), global bus free (bit 3), coalescer ready (bit 4) and outstanding-request check passing (bit 5).
- R5: A scalar global-memory instruction needs three conditions: scalar memory issue ready (bit 6), scalar bus free (bit 7) and scalar request FIFO room (bit 8).
- R6: A vector local-memory instruction needs three conditions: local issue ready (bit 9), local bus free (bit 10) and local request FIFO room (bit 11).
- R7: A vector flat instruction needs the following. Both issue units ready, else bit 12. Both buses free, else bit 13. Coalescer ready, else bit 14. Outstanding check passing, else bit 15. Local FIFO room, else bit 16.
- R8: Every failing condition raises its own stall bit in the same cycle. `disp_rdy` is high exactly when the class is known and no stall bit is set.
- R9: A scalar local-memory or scalar flat instruction, or one with no class bit set, raises `class_err`. It is never ready, raises no stall bit, and changes no counter.
- R10: Counter i (bits [i*CNT_W +: CNT_W] of `evt_cnt`) counts cycles with stall bit i set, for i from 0 to 16. Counter 17 counts cycles with `disp_rdy` high. Each counter saturates at its maximum.
- R11: `cnt_clr` zeroes all counters on the next edge and takes priority over any increment in that cycle.
- R12: While `chk_vld` is low, `disp_rdy`, `class_err` and all stall bits are low and no counter changes.
- R13: After reset all counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_clr | input | 1 | Synchronous clear of all counters |
| chk_vld | input | 1 | Candidate instruction present |
| inst_scalar | input | 1 | Instruction is scalar |
| inst_nop | input | 1 | No-op class |
| inst_eop | input | 1 | End-of-program class |
| inst_barrier | input | 1 | Barrier class |
| inst_branch | input | 1 | Branch class |
| inst_alu | input | 1 | ALU class |
| inst_gmem | input | 1 | Global memory class |
| inst_lmem | input | 1 | Local memory class |
| inst_flat | input | 1 | Flat memory class |
| salu_rdy | input | 1 | Scalar ALU ready next cycle |
| valu_rdy | input | 1 | Vector ALU ready next cycle |
| gm_issue_rdy | input | 1 | Global memory issue unit ready |
| gm_bus_free | input | 1 | Register-to-global bus free |
| coal_rdy | input | 1 | Coalescer ready |
| outst_ok | input | 1 | Outstanding-request check passes |
| sm_issue_rdy | input | 1 | Scalar memory issue unit ready |
| sm_bus_free | input | 1 | Scalar memory bus free |
| sm_fifo_room | input | 1 | Scalar request FIFO has room for the wave |
| lm_issue_rdy | input | 1 | Local memory issue unit ready |
| lm_bus_free | input | 1 | Register-to-local bus free |
| lm_fifo_room | input | 1 | Local request FIFO has room for the wave |
| disp_rdy | output | 1 | Candidate may dispatch |
| stall_vec | output | 17 | One strobe per failing condition |
| class_err | output | 1 | Class combination not recognised |
| evt_cnt | output | 18*CNT_W | Packed saturating event counters |

## Verification
The assertions check on every cycle that a ready answer never comes with a stall strobe, and that an error never comes with ready. They also check that an idle cycle is quiet, that a vector end-of-program is always accepted, and that every counter holds, clears and saturates correctly. Only the bench scenarios show that each class reads the right resource flags and raises the right bit positions, that the resource of the other kind is ignored, and that several reasons are reported together. The same applies to the exact counter values after a mix of outcomes, to saturation at the ceiling, and to clear winning over a simultaneous increment.

// File: rtl/disp_rdy_pkg.sv
package disp_rdy_pkg;

  typedef enum logic [2:0] {
    CK_NOP, CK_EOP, CK_ALU, CK_VGM, CK_SGM, CK_LCL, CK_FLAT, CK_BAD
  } iclass_e;

  typedef struct packed {
    logic salu;
    logic valu;
    logic gm_issue;
    logic gm_bus;
    logic coal;
    logic outst;
    logic sm_issue;
    logic sm_bus;
    logic sm_fifo;
    logic lm_issue;
    logic lm_bus;
    logic lm_fifo;
  } res_t;

  localparam int unsigned SB_SALU       = 0;
  localparam int unsigned SB_VALU       = 1;
  localparam int unsigned SB_VGM_ISSUE  = 2;
  localparam int unsigned SB_VGM_BUS    = 3;
  localparam int unsigned SB_VGM_COAL   = 4;
  localparam int unsigned SB_VGM_OUTST  = 5;
  localparam int unsigned SB_SGM_ISSUE  = 6;
  localparam int unsigned SB_SGM_BUS    = 7;
  localparam int unsigned SB_SGM_FIFO   = 8;
  localparam int unsigned SB_LCL_ISSUE  = 9;
  localparam int unsigned SB_LCL_BUS    = 10;
  localparam int unsigned SB_LCL_FIFO   = 11;
  localparam int unsigned SB_FLAT_ISSUE = 12;
  localparam int unsigned SB_FLAT_BUS   = 13;
  localparam int unsigned SB_FLAT_COAL  = 14;
  localparam int unsigned SB_FLAT_OUTST = 15;
  localparam int unsigned SB_FLAT_FIFO  = 16;
  localparam int unsigned NUM_STALL     = 17;
  localparam int unsigned EV_READY      = NUM_STALL;
  localparam int unsigned NUM_EVT       = NUM_STALL + 1;

endpackage

// File: rtl/dr_class_decode.sv
module dr_class_decode
  import disp_rdy_pkg::*;
(
  input  logic    is_scalar,
  input  logic    is_nop,
  input  logic    is_eop,
  input  logic    is_barrier,
  input  logic    is_branch,
  input  logic    is_alu,
  input  logic    is_gmem,
  input  logic    is_lmem,
  input  logic    is_flat,
  output iclass_e cls
);

  // Priority order is part of the behaviour: earlier classes win.
  always_comb begin
    if (is_nop)                                 cls = CK_NOP;
    else if (is_eop)                            cls = CK_EOP;
    else if (is_barrier || is_branch || is_alu) cls = CK_ALU;
    else if (is_gmem && !is_scalar)             cls = CK_VGM;
    else if (is_gmem && is_scalar)              cls = CK_SGM;
    else if (is_lmem && !is_scalar)             cls = CK_LCL;
    else if (is_flat && !is_scalar)             cls = CK_FLAT;
    else                                        cls = CK_BAD;
  end

endmodule

// File: rtl/dr_rule_eval.sv
module dr_rule_eval
  import disp_rdy_pkg::*;
(
  input  iclass_e              cls,
  input  logic                 is_scalar,
  input  res_t                 res,
  output logic [NUM_STALL-1:0] fail,
  output logic                 pass,
  output logic                 bad
);

  always_comb begin
    fail = '0;
    bad  = 1'b0;
    unique case (cls)
      CK_NOP, CK_ALU: begin
        if (is_scalar) fail[SB_SALU] = !res.salu;
        else           fail[SB_VALU] = !res.valu;
      end
      CK_EOP: begin
        if (is_scalar) fail[SB_SALU] = !res.salu;
      end
      CK_VGM: begin
        fail[SB_VGM_ISSUE] = !res.gm_issue;
        fail[SB_VGM_BUS]   = !res.gm_bus;
        fail[SB_VGM_COAL]  = !res.coal;
        fail[SB_VGM_OUTST] = !res.outst;
      end
      CK_SGM: begin
        fail[SB_SGM_ISSUE] = !res.sm_issue;
        fail[SB_SGM_BUS]   = !res.sm_bus;
        fail[SB_SGM_FIFO]  = !res.sm_fifo;
      end
      CK_LCL: begin
        fail[SB_LCL_ISSUE] = !res.lm_issue;
        fail[SB_LCL_BUS]   = !res.lm_bus;
        fail[SB_LCL_FIFO]  = !res.lm_fifo;
      end
      CK_FLAT: begin
        fail[SB_FLAT_ISSUE] = !(res.gm_issue && res.lm_issue);
        fail[SB_FLAT_BUS]   = !(res.gm_bus && res.lm_bus);
        fail[SB_FLAT_COAL]  = !res.coal;
        fail[SB_FLAT_OUTST] = !res.outst;
        fail[SB_FLAT_FIFO]  = !res.lm_fifo;
      end
      default: bad = 1'b1;
    endcase
    pass = !bad && (fail == '0);
  end

endmodule

// File: rtl/dr_sat_counter.sv
module dr_sat_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);

  localparam logic [W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt <= '0;
    else if (clr)                    cnt <= '0;
    else if (inc && cnt != CNT_MAX)  cnt <= cnt + 1'b1;
  end

  AST_CNT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt == '0); // R11
  AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && cnt == CNT_MAX) |=> cnt == CNT_MAX); // R10
  AST_CNT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !inc) |=> $stable(cnt)); // R10

endmodule

// File: rtl/disp_ready_chk.sv
module disp_ready_chk
  import disp_rdy_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cnt_clr,
  input  logic                       chk_vld,
  input  logic                       inst_scalar,
  input  logic                       inst_nop,
  input  logic                       inst_eop,
  input  logic                       inst_barrier,
  input  logic                       inst_branch,
  input  logic                       inst_alu,
  input  logic                       inst_gmem,
  input  logic                       inst_lmem,
  input  logic                       inst_flat,
  input  logic                       salu_rdy,
  input  logic                       valu_rdy,
  input  logic                       gm_issue_rdy,
  input  logic                       gm_bus_free,
  input  logic                       coal_rdy,
  input  logic                       outst_ok,
  input  logic                       sm_issue_rdy,
  input  logic                       sm_bus_free,
  input  logic                       sm_fifo_room,
  input  logic                       lm_issue_rdy,
  input  logic                       lm_bus_free,
  input  logic                       lm_fifo_room,
  output logic                       disp_rdy,
  output logic [NUM_STALL-1:0]       stall_vec,
  output logic                       class_err,
  output logic [NUM_EVT*CNT_W-1:0]   evt_cnt
);

  iclass_e              cls;
  res_t                 res;
  logic [NUM_STALL-1:0] fail;
  logic                 pass;
  logic                 bad;
  logic [NUM_EVT-1:0]   evt_inc;

  assign res = '{salu: salu_rdy, valu: valu_rdy, gm_issue: gm_issue_rdy,
                 gm_bus: gm_bus_free, coal: coal_rdy, outst: outst_ok,
                 sm_issue: sm_issue_rdy, sm_bus: sm_bus_free,
                 sm_fifo: sm_fifo_room, lm_issue: lm_issue_rdy,
                 lm_bus: lm_bus_free, lm_fifo: lm_fifo_room};

  dr_class_decode u_decode (
    .is_scalar  (inst_scalar),
    .is_nop     (inst_nop),
    .is_eop     (inst_eop),
    .is_barrier (inst_barrier),
    .is_branch  (inst_branch),
    .is_alu     (inst_alu),
    .is_gmem    (inst_gmem),
    .is_lmem    (inst_lmem),
    .is_flat    (inst_flat),
    .cls        (cls)
  );

  dr_rule_eval u_rules (
    .cls       (cls),
    .is_scalar (inst_scalar),
    .res       (res),
    .fail      (fail),
    .pass      (pass),
    .bad       (bad)
  );

  assign disp_rdy  = chk_vld && pass;
  assign class_err = chk_vld && bad;
  assign stall_vec = chk_vld ? fail : '0;
  assign evt_inc   = {disp_rdy, stall_vec};

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_cnt
    dr_sat_counter #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (cnt_clr),
      .inc   (evt_inc[i]),
      .cnt   (evt_cnt[i*CNT_W +: CNT_W])
    );
  end

  AST_READY_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    disp_rdy |-> stall_vec == '0); // R8
  AST_ERR_NEVER_READY: assert property (@(posedge clk) disable iff (!rst_n)
    class_err |-> (!disp_rdy && stall_vec == '0)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_vld |-> (!disp_rdy && !class_err && stall_vec == '0)); // R12
  AST_VEC_EOP_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_vld && inst_eop && !inst_nop && !inst_scalar) |-> disp_rdy); // R2

endmodule

// File: tb/disp_ready_chk_bench.sv
module disp_ready_chk_bench;
  localparam int CW = 4;
  localparam int NE = 18;
  localparam int NS = 17;

  // class bits {flat,lmem,gmem,alu,branch,barrier,eop,nop,scalar}
  localparam logic [8:0] C_SC = 9'h001, C_NOP = 9'h002, C_EOP = 9'h004,
    C_BAR = 9'h008, C_BR = 9'h010, C_ALU = 9'h020, C_GM = 9'h040,
    C_LM = 9'h080, C_FL = 9'h100;
  // flag bits, see port list order
  localparam logic [11:0] F_SALU = 12'h001, F_VALU = 12'h002,
    F_GMI = 12'h004, F_GMB = 12'h008, F_COAL = 12'h010, F_OUT = 12'h020,
    F_SMF = 12'h100, F_LMI = 12'h200, F_LMB = 12'h400, F_ALL = 12'hFFF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic clr = 1'b0, vld = 1'b0;
  logic [8:0]  cls = '0;
  logic [11:0] fl = '0;
  logic disp_rdy, class_err;
  logic [NS-1:0] stall_vec;
  logic [NE*CW-1:0] evt_cnt;
  int exp_cnt [NE];
  int n_chk = 0, n_err = 0;

  always #4 clk = ~clk;

  disp_ready_chk #(.CNT_W(CW)) u_disp_ready_chk (
    .clk(clk), .rst_n(rst_n), .cnt_clr(clr), .chk_vld(vld),
    .inst_scalar(cls[0]), .inst_nop(cls[1]), .inst_eop(cls[2]),
    .inst_barrier(cls[3]), .inst_branch(cls[4]), .inst_alu(cls[5]),
    .inst_gmem(cls[6]), .inst_lmem(cls[7]), .inst_flat(cls[8]),
    .salu_rdy(fl[0]), .valu_rdy(fl[1]), .gm_issue_rdy(fl[2]),
    .gm_bus_free(fl[3]), .coal_rdy(fl[4]), .outst_ok(fl[5]),
    .sm_issue_rdy(fl[6]), .sm_bus_free(fl[7]), .sm_fifo_room(fl[8]),
    .lm_issue_rdy(fl[9]), .lm_bus_free(fl[10]), .lm_fifo_room(fl[11]),
    .disp_rdy(disp_rdy), .stall_vec(stall_vec), .class_err(class_err),
    .evt_cnt(evt_cnt)
  );

  function automatic logic [NS-1:0] sb(input int i);
    return NS'(1) << i;
  endfunction

  task automatic check_cnts(input string tag);
    n_chk++;
    for (int i = 0; i < NE; i++) begin
      if (int'(evt_cnt[i*CW +: CW]) != exp_cnt[i]) begin
        n_err++;
        $display("FAIL %s counter %0d actual=%0d expected=%0d", tag, i,
                 evt_cnt[i*CW +: CW], exp_cnt[i]);
        break;
      end
    end
  endtask

  // Apply one candidate for one cycle, check outputs, then counters.
  task automatic present(input logic v, input logic [8:0] c,
                         input logic [11:0] f, input logic cl,
                         input logic er, input logic ee,
                         input logic [NS-1:0] es, input string tag);
    @(negedge clk);
    vld = v; cls = c; fl = f; clr = cl;
    #1;
    n_chk++;
    if (disp_rdy !== er || class_err !== ee || stall_vec !== es) begin
      n_err++;
      $display("FAIL %s rdy/err/stall actual=%b/%b/%h expected=%b/%b/%h",
               tag, disp_rdy, class_err, stall_vec, er, ee, es);
    end
    @(posedge clk);
    #1;
    for (int i = 0; i < NE; i++) begin
      if (cl) exp_cnt[i] = 0;
      else if ((i < NS ? es[i] : er) && exp_cnt[i] < (1 << CW) - 1)
        exp_cnt[i]++;
    end
    check_cnts(tag);
    vld = 1'b0; clr = 1'b0;
  endtask

  task automatic t_reset;
    #1;
    n_chk++;
    if (disp_rdy !== 1'b0 || class_err !== 1'b0 || stall_vec !== '0) begin
      n_err++;
      $display("FAIL R13 outputs after reset actual=%b/%b/%h expected=0/0/0",
               disp_rdy, class_err, stall_vec);
    end
    check_cnts("R13");
  endtask

  task automatic t_nop;
    present(1, C_NOP | C_SC, F_ALL & ~F_SALU, 0, 0, 0, sb(0), "R1");
    present(1, C_NOP, F_ALL & ~F_VALU, 0, 0, 0, sb(1), "R1");
    present(1, C_NOP, F_VALU, 0, 1, 0, '0, "R1");
  endtask

  task automatic t_eop;
    present(1, C_EOP, 12'h000, 0, 1, 0, '0, "R2");
    present(1, C_EOP | C_SC, F_ALL & ~F_SALU, 0, 0, 0, sb(0), "R2");
  endtask

  task automatic t_alu;
    present(1, C_BR | C_SC, F_VALU, 0, 0, 0, sb(0), "R3");
    present(1, C_BAR, F_SALU, 0, 0, 0, sb(1), "R3");
    present(1, C_ALU, F_ALL, 0, 1, 0, '0, "R3");
  endtask

  task automatic t_vgm;
    present(1, C_GM, 12'h000, 0, 0, 0, sb(2)|sb(3)|sb(4)|sb(5), "R4");
    present(1, C_GM, F_ALL & ~F_COAL, 0, 0, 0, sb(4), "R4");
    present(1, C_GM, F_ALL, 0, 1, 0, '0, "R4");
  endtask

  task automatic t_sgm;
    present(1, C_GM | C_SC, 12'h000, 0, 0, 0, sb(6)|sb(7)|sb(8), "R5");
    present(1, C_GM | C_SC, F_ALL & ~F_SMF, 0, 0, 0, sb(8), "R5");
  endtask

  task automatic t_lcl;
    present(1, C_LM, 12'h000, 0, 0, 0, sb(9)|sb(10)|sb(11), "R6");
    present(1, C_LM, F_ALL & ~F_LMB, 0, 0, 0, sb(10), "R6");
  endtask

  task automatic t_flat;
    present(1, C_FL, F_ALL & ~F_LMI, 0, 0, 0, sb(12), "R7");
    present(1, C_FL, F_ALL & ~F_GMB, 0, 0, 0, sb(13), "R7");
    present(1, C_FL, F_ALL & ~F_OUT, 0, 0, 0, sb(15), "R7");
    present(1, C_FL, 12'h000, 0, 0, 0,
            sb(12)|sb(13)|sb(14)|sb(15)|sb(16), "R8");
    present(1, C_FL, F_ALL, 0, 1, 0, '0, "R7");
  endtask

  task automatic t_unknown;
    present(1, 9'h000, F_ALL, 0, 0, 1, '0, "R9");
    present(1, C_FL | C_SC, F_ALL, 0, 0, 1, '0, "R9");
    present(1, C_LM | C_SC, 12'h000, 0, 0, 1, '0, "R9");
  endtask

  task automatic t_idle;
    present(0, C_GM, 12'h000, 0, 0, 0, '0, "R12");
    present(0, C_ALU, F_ALL, 0, 0, 0, '0, "R12");
  endtask

  task automatic t_saturate;
    for (int k = 0; k < 20; k++)
      present(1, C_NOP | C_SC, 12'h000, 0, 0, 0, sb(0), "R10");
    present(1, C_ALU, F_ALL, 0, 1, 0, '0, "R10");
  endtask

  task automatic t_clear;
    present(1, C_NOP | C_SC, 12'h000, 1, 0, 0, sb(0), "R11");
    present(1, C_GM, F_ALL & ~F_GMI, 0, 0, 0, sb(2), "R11");
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #(8 * 100000);
    n_err++; n_chk++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < NE; i++) exp_cnt[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_nop();
    t_eop();
    t_alu();
    t_vgm();
    t_sgm();
    t_lcl();
    t_flat();
    t_unknown();
    t_idle();
    t_saturate();
    t_clear();
    finish_run();
  end

endmodule